// File: doc/BRIEF.md
# Level and Priority Interrupt Controller

This block gathers up to 63 interrupt request lines and turns them into a 7-bit vector of pending interrupt levels for a processor. Each request is first qualified against a per-source mask register. It is then routed to one of seven levels. Sources 1 to 7 are wired to their own level. Sources 8 to 63 each have a small control register that software writes over a simple register bus. That register chooses the source's level and its priority inside the level.

Within one level there are nine ordered slots. Four programmable slots (priorities 7 down to 4) sit above the hardwired source of that level. Four more (priorities 3 down to 0) sit below it. When the processor acknowledges a level, the block picks the best pending source at that level and returns its number and its vector. If nothing is pending at that level, it returns a fixed spurious vector. Request inputs are taken as levels. Clearing a request is up to the peripheral.

Top module: `lvl_prio_intc`

## Requirements
- R1: Output bit `irq_lvl_o[L]` (L = 1..7) is high one clock after any cycle in which an unmasked active request maps to level L. It is low one clock after a cycle in which none does.
- R2: Mask bit n blocks source n when set. After reset every mask bit is 1, both mask words read 0xFFFFFFFF, and `irq_lvl_o` is all zero.
- R3: Source k (k = 1..7) always belongs to level k and sits in the fixed middle slot of that level. Bus addresses 0..7 read as zero, and writes to them are ignored.
- R4: The control register of source n (8..63) is at bus address n. Priority is in bits [2:0] and level is in bits [5:3]. All higher bits read as zero. A control register value written takes effect on the next request evaluation. A source whose level is 0 never asserts any IRQ bit and is never selected.
- R5: The order inside a level, from best to worst, is: programmable priority 7, 6, 5, 4, then the hardwired source, then programmable priority 3, 2, 1, 0.
- R6: When programmable sources at the same level have equal priority, the lower source number wins.
- R7: A one-cycle `ack_i` with `ack_lvl_i` gives a one-cycle `ack_vld_o` on the next clock. `ack_src_o` then holds the winning source, and `ack_vec_o` holds 64 plus that source number. The winner is chosen from the requests and mask seen in the `ack_i` cycle.
- R8: When no recognised source is pending at the acknowledged level, or that level is 0, the block returns vector 24 with source 0.
- R9: Bus address 64 holds mask bits 31..0 and address 65 holds mask bits 63..32. Any other address above 63 reads as zero.
- R10: Request bit 0 names no source and never has any effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 64 | Level request lines, bit n for source n (bit 0 unused) |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| ack_i | input | 1 | Acknowledge pulse |
| ack_lvl_i | input | 3 | Level being acknowledged |
| irq_lvl_o | output | 7 | Pending-level vector, bits [7:1] |
| ack_vld_o | output | 1 | Acknowledge result valid |
| ack_src_o | output | 6 | Winning source number (0 if spurious) |
| ack_vec_o | output | 8 | Returned vector |

## Verification
On every cycle, the assertions check several properties. An unmasked request on a hardwired source raises its own level bit on the next clock. A fully set mask silences all level outputs. Every acknowledge pulse yields exactly one valid cycle. A non-spurious winner was an active, unmasked request in the acknowledge cycle. A spurious answer carries source 0, and acknowledging level 0 is always spurious. The assertions also check that control-register reads keep their high bits at zero. The slot order inside a level, the tie-break between equal priorities, the effect of reprogramming a source, and the exact vector values can only be shown by the bench's scenarios with known programming.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam int LVL_W  = 3;
   localparam int PRI_W  = 3;
   localparam int RANK_W = 4;
   localparam int CR_W   = LVL_W + PRI_W;
   typedef logic [LVL_W-1:0]  lvl_t;
   typedef logic [PRI_W-1:0]  pri_t;
   typedef logic [RANK_W-1:0] rank_t;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
   import intc_pkg::*;
#(
   parameter int NUM_SRC   = 64,
   parameter int NUM_FIXED = 7,
   parameter int DW        = 32,
   parameter int AW        = 7
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_we,
   input  logic [AW-1:0]          bus_addr,
   input  logic [DW-1:0]          bus_wdata,
   output logic [DW-1:0]          bus_rdata,
   output lvl_t [NUM_SRC-1:0]     src_lvl,
   output pri_t [NUM_SRC-1:0]     src_pri,
   output logic [NUM_SRC-1:0]     mask_q
);
   localparam int MASK_WORDS = NUM_SRC / DW;
   localparam int SRC_W      = $clog2(NUM_SRC);

   logic [NUM_SRC-1:0][CR_W-1:0] cr_rd;

   // per-source control storage: hardwired sources hold no flops
   for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      if (n <= NUM_FIXED) begin : g_fix
         assign src_lvl[n] = LVL_W'(n);
         assign src_pri[n] = '0;
         assign cr_rd[n]   = '0;
      end else begin : g_prog
         logic [CR_W-1:0] cr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cr_q <= '0;
            else if (bus_we && bus_addr == AW'(n))
               cr_q <= bus_wdata[CR_W-1:0];
         end
         assign src_lvl[n] = cr_q[CR_W-1:PRI_W];
         assign src_pri[n] = cr_q[PRI_W-1:0];
         assign cr_rd[n]   = cr_q;
      end
   end

   // mask words, all bits set at reset
   for (genvar w = 0; w < MASK_WORDS; w++) begin : g_mask
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mask_q[w*DW +: DW] <= '1;
         else if (bus_we && bus_addr == AW'(NUM_SRC + w))
            mask_q[w*DW +: DW] <= bus_wdata;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr < AW'(NUM_SRC))
         bus_rdata[CR_W-1:0] = cr_rd[bus_addr[SRC_W-1:0]];
      for (int w = 0; w < MASK_WORDS; w++)
         if (bus_addr == AW'(NUM_SRC + w))
            bus_rdata = mask_q[w*DW +: DW];
   end
endmodule

// File: rtl/intc_recog.sv
module intc_recog
   import intc_pkg::*;
#(
   parameter int NUM_SRC   = 64,
   parameter int NUM_FIXED = 7,
   parameter int NUM_LVL   = 7
) (
   input  logic [NUM_SRC-1:0]     req_i,
   input  logic [NUM_SRC-1:0]     mask_q,
   input  lvl_t [NUM_SRC-1:0]     src_lvl,
   input  pri_t [NUM_SRC-1:0]     src_pri,
   output logic [NUM_SRC-1:0]     act,
   output rank_t [NUM_SRC-1:0]    rank,
   output logic [NUM_LVL:1]       irq_d
);
   // slot rank: upper half of priorities sits above the fixed middle slot
   localparam int    UPPER    = 1 << (PRI_W - 1);
   localparam rank_t MID_RANK = RANK_W'(UPPER);

   for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      if (n == 0) begin : g_none
         assign act[n]  = 1'b0;
         assign rank[n] = '0;
      end else if (n <= NUM_FIXED) begin : g_fix
         assign act[n]  = req_i[n] & ~mask_q[n];
         assign rank[n] = MID_RANK;
      end else begin : g_prog
         assign act[n]  = req_i[n] & ~mask_q[n] & (src_lvl[n] != '0);
         assign rank[n] = (src_pri[n] >= PRI_W'(UPPER)) ?
                          RANK_W'(src_pri[n]) + RANK_W'(1) : RANK_W'(src_pri[n]);
      end
   end

   always_comb begin
      irq_d = '0;
      for (int l = 1; l <= NUM_LVL; l++)
         for (int n = 1; n < NUM_SRC; n++)
            if (act[n] && src_lvl[n] == LVL_W'(l))
               irq_d[l] = 1'b1;
   end
endmodule

// File: rtl/intc_arb.sv
module intc_arb
   import intc_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int SRC_W   = 6
) (
   input  logic [NUM_SRC-1:0]  act,
   input  lvl_t [NUM_SRC-1:0]  src_lvl,
   input  rank_t [NUM_SRC-1:0] rank,
   input  lvl_t                lvl_sel,
   output logic                hit,
   output logic [SRC_W-1:0]    win_src
);
   rank_t best;

   // descending scan with >= leaves the lowest number among equal ranks
   always_comb begin
      hit     = 1'b0;
      win_src = '0;
      best    = '0;
      for (int n = NUM_SRC - 1; n >= 1; n--) begin
         if (lvl_sel != '0 && act[n] && src_lvl[n] == lvl_sel &&
             (!hit || rank[n] >= best)) begin
            hit     = 1'b1;
            best    = rank[n];
            win_src = SRC_W'(n);
         end
      end
   end
endmodule

// File: rtl/lvl_prio_intc.sv
module lvl_prio_intc
   import intc_pkg::*;
#(
   parameter int NUM_SRC   = 64,
   parameter int NUM_FIXED = 7,
   parameter int NUM_LVL   = 7,
   parameter int DW        = 32,
   parameter int VEC_W     = 8,
   parameter int VEC_BASE  = 64,
   parameter int SPUR_VEC  = 24,
   localparam int SRC_W    = $clog2(NUM_SRC),
   localparam int AW       = $clog2(NUM_SRC + NUM_SRC / DW)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   input  logic               bus_we,
   input  logic [AW-1:0]      bus_addr,
   input  logic [DW-1:0]      bus_wdata,
   output logic [DW-1:0]      bus_rdata,
   input  logic               ack_i,
   input  logic [LVL_W-1:0]   ack_lvl_i,
   output logic [NUM_LVL:1]   irq_lvl_o,
   output logic               ack_vld_o,
   output logic [SRC_W-1:0]   ack_src_o,
   output logic [VEC_W-1:0]   ack_vec_o
);
   if (NUM_SRC % DW != 0) begin : g_bad_dw
      $error("NUM_SRC must be a multiple of DW");
   end
   if (NUM_FIXED != NUM_LVL || NUM_LVL >= (1 << LVL_W)) begin : g_bad_lvl
      $error("one hardwired source per level, levels must fit the level field");
   end
   if (VEC_BASE + NUM_SRC > (1 << VEC_W) || SPUR_VEC >= (1 << VEC_W)) begin : g_bad_vec
      $error("vectors do not fit VEC_W");
   end

   lvl_t  [NUM_SRC-1:0] src_lvl;
   pri_t  [NUM_SRC-1:0] src_pri;
   rank_t [NUM_SRC-1:0] rank;
   logic  [NUM_SRC-1:0] mask_q;
   logic  [NUM_SRC-1:0] act;
   logic  [NUM_LVL:1]   irq_d;
   logic                hit;
   logic  [SRC_W-1:0]   win_src;

   intc_regs #(.NUM_SRC(NUM_SRC), .NUM_FIXED(NUM_FIXED), .DW(DW), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .src_lvl(src_lvl), .src_pri(src_pri), .mask_q(mask_q));

   intc_recog #(.NUM_SRC(NUM_SRC), .NUM_FIXED(NUM_FIXED), .NUM_LVL(NUM_LVL)) u_recog (
      .req_i(req_i), .mask_q(mask_q), .src_lvl(src_lvl), .src_pri(src_pri),
      .act(act), .rank(rank), .irq_d(irq_d));

   intc_arb #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_arb (
      .act(act), .src_lvl(src_lvl), .rank(rank), .lvl_sel(ack_lvl_i),
      .hit(hit), .win_src(win_src));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_lvl_o <= '0;
         ack_vld_o <= 1'b0;
         ack_src_o <= '0;
         ack_vec_o <= VEC_W'(SPUR_VEC);
      end else begin
         irq_lvl_o <= irq_d;
         ack_vld_o <= ack_i;
         if (ack_i) begin
            ack_src_o <= hit ? win_src : '0;
            ack_vec_o <= hit ? VEC_W'(VEC_BASE) + VEC_W'(win_src) : VEC_W'(SPUR_VEC);
         end
      end
   end
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
   parameter int NUM_SRC   = 64,
   parameter int NUM_FIXED = 7,
   parameter int NUM_LVL   = 7,
   parameter int DW        = 32,
   parameter int VEC_W     = 8,
   parameter int SPUR_VEC  = 24,
   parameter int SRC_W     = 6,
   parameter int AW        = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] req_i,
   input logic               ack_i,
   input logic [2:0]         ack_lvl_i,
   input logic [NUM_LVL:1]   irq_lvl_o,
   input logic               ack_vld_o,
   input logic [SRC_W-1:0]   ack_src_o,
   input logic [VEC_W-1:0]   ack_vec_o,
   input logic [AW-1:0]      bus_addr,
   input logic [DW-1:0]      bus_rdata,
   input logic [NUM_SRC-1:0] mask_q
);
   // R7
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_i |=> ack_vld_o);
   // R7
   ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_i |=> !ack_vld_o);
   // R7
   winner_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && ack_lvl_i != 3'd0) ##1 (ack_vld_o && ack_vec_o != VEC_W'(SPUR_VEC))
      |-> (($past(req_i & ~mask_q) >> ack_src_o) & NUM_SRC'(1)) != '0);
   // R8
   spur_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_vld_o && ack_vec_o == VEC_W'(SPUR_VEC)) |-> ack_src_o == '0);
   // R8
   lvl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && ack_lvl_i == 3'd0) |=> ack_vec_o == VEC_W'(SPUR_VEC));
   // R2
   all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_q) |=> irq_lvl_o == '0);
   // R4
   cr_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr < AW'(NUM_SRC)) |-> bus_rdata[DW-1:6] == '0);

   for (genvar k = 1; k <= NUM_FIXED; k++) begin : g_fix
      // R3
      fixed_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_i[k] && !mask_q[k]) |=> irq_lvl_o[k]);
   end
endmodule

bind lvl_prio_intc intc_chk #(
   .NUM_SRC(NUM_SRC), .NUM_FIXED(NUM_FIXED), .NUM_LVL(NUM_LVL), .DW(DW),
   .VEC_W(VEC_W), .SPUR_VEC(SPUR_VEC), .SRC_W(SRC_W), .AW(AW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_i(ack_i), .ack_lvl_i(ack_lvl_i),
   .irq_lvl_o(irq_lvl_o), .ack_vld_o(ack_vld_o), .ack_src_o(ack_src_o),
   .ack_vec_o(ack_vec_o), .bus_addr(bus_addr), .bus_rdata(bus_rdata), .mask_q(mask_q));

// File: tb/tb_lvl_prio_intc.sv
module tb_lvl_prio_intc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] req = '0;
   logic        bus_we = 1'b0;
   logic [6:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        ack_i = 1'b0;
   logic [2:0]  ack_lvl = '0;
   logic [7:1]  irq;
   logic        ack_vld;
   logic [5:0]  ack_src;
   logic [7:0]  ack_vec;
   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   lvl_prio_intc dut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ack_i(ack_i), .ack_lvl_i(ack_lvl),
      .irq_lvl_o(irq), .ack_vld_o(ack_vld), .ack_src_o(ack_src), .ack_vec_o(ack_vec));

   typedef struct packed {
      logic [63:0] req;
      logic [63:0] mask;
      logic [2:0]  lvl;
      logic [7:1]  irq;
      logic [7:0]  vec;
   } row_t;

   // programming used by the table: 8:L3P7 9:L3P4 10:L3P3 11:L3P0 12:L3P3 20:L5P2 30:L0P7 40:L7P5
   localparam int NROWS = 19;
   localparam row_t ROWS [NROWS] = '{
      '{64'h8,                  64'h0,  3'd3, 7'b0000100, 8'd67},  // R3 fixed alone
      '{64'hC08,                64'h0,  3'd3, 7'b0000100, 8'd67},  // R5 fixed above P3,P0
      '{64'h208,                64'h0,  3'd3, 7'b0000100, 8'd73},  // R5 P4 above fixed
      '{64'h308,                64'h0,  3'd3, 7'b0000100, 8'd72},  // R5 P7 on top
      '{64'h1400,               64'h0,  3'd3, 7'b0000100, 8'd74},  // R6 tie, 10 beats 12
      '{64'h1800,               64'h0,  3'd3, 7'b0000100, 8'd76},  // R5 P3 over P0
      '{64'h108,                64'h100,3'd3, 7'b0000100, 8'd67},  // R2 masked P7
      '{64'h4000_0000,          64'h0,  3'd3, 7'b0000000, 8'd24},  // R4 level 0 silent
      '{64'h0000_0100_0010_0002,64'h0,  3'd5, 7'b1010001, 8'd84},  // R1 R7 level 5
      '{64'h0000_0100_0010_0002,64'h0,  3'd7, 7'b1010001, 8'd104}, // R7 level 7
      '{64'h0000_0100_0010_0002,64'h0,  3'd1, 7'b1010001, 8'd65},  // R3 level 1
      '{64'h1,                  64'h0,  3'd1, 7'b0000000, 8'd24},  // R10 bit 0
      '{64'h4,                  64'h0,  3'd3, 7'b0000010, 8'd24},  // R8 empty level
      '{64'hFFFF_FFFF_FFFF_FFFF,64'hFFFF_FFFF_FFFF_FFFF, 3'd3, 7'b0000000, 8'd24}, // R2
      '{64'hFFFF_FFFF_FFFF_FFFF,64'h0,  3'd0, 7'b1111111, 8'd24},  // R8 level 0 ack
      '{64'hFFFF_FFFF_FFFF_FFFF,64'h0,  3'd4, 7'b1111111, 8'd68},  // R3 only fixed
      '{64'hFFFF_FFFF_FFFF_FFFF,64'h0,  3'd3, 7'b1111111, 8'd72},  // R5 full level
      '{64'hFFFF_FFFF_FFFF_FFFF,64'h0,  3'd5, 7'b1111111, 8'd69},  // R5 fixed over P2
      '{64'hFFFF_FFFF_FFFF_FFFF,64'h0,  3'd7, 7'b1111111, 8'd104}  // R5 P5 over fixed
   };

   task automatic chk(string req_tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
      end
   endtask

   task automatic bus_wr(logic [6:0] a, logic [31:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_rd_chk(string tag, logic [6:0] a, logic [31:0] exp);
      bus_addr = a;
      #1;
      chk(tag, 64'(bus_rdata), 64'(exp));
   endtask

   task automatic do_ack(logic [63:0] r, logic [2:0] l);
      req = r; ack_i = 1'b1; ack_lvl = l;
      @(negedge clk);
      ack_i = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 reset state
      chk("R2 irq after reset", 64'(irq), 64'h0);
      chk("R7 vld after reset", 64'(ack_vld), 64'h0);
      bus_rd_chk("R2 mask lo reset", 7'd64, 32'hFFFF_FFFF);
      bus_rd_chk("R2 mask hi reset", 7'd65, 32'hFFFF_FFFF);
      bus_rd_chk("R4 ctrl reset", 7'd8, 32'h0);

      bus_wr(7'd8,  {26'd0, 3'd3, 3'd7});
      bus_wr(7'd9,  {26'd0, 3'd3, 3'd4});
      bus_wr(7'd10, {26'd0, 3'd3, 3'd3});
      bus_wr(7'd11, {26'd0, 3'd3, 3'd0});
      bus_wr(7'd12, {26'd0, 3'd3, 3'd3});
      bus_wr(7'd20, {26'd0, 3'd5, 3'd2});
      bus_wr(7'd30, {26'd0, 3'd0, 3'd7});
      bus_wr(7'd40, {26'd0, 3'd7, 3'd5});
      bus_rd_chk("R4 ctrl readback", 7'd9, 32'h1C);

      for (int i = 0; i < NROWS; i++) begin
         bus_wr(7'd64, ROWS[i].mask[31:0]);
         bus_wr(7'd65, ROWS[i].mask[63:32]);
         do_ack(ROWS[i].req, ROWS[i].lvl);
         chk($sformatf("R1 row %0d irq", i), 64'(irq), 64'(ROWS[i].irq));
         chk($sformatf("R7 row %0d vld", i), 64'(ack_vld), 64'h1);
         chk($sformatf("R5 R8 row %0d vec", i), 64'(ack_vec), 64'(ROWS[i].vec));
         chk($sformatf("R7 row %0d src", i), 64'(ack_src),
             (ROWS[i].vec == 8'd24) ? 64'h0 : 64'(ROWS[i].vec - 8'd64));
      end

      // R7 valid lasts one cycle
      @(negedge clk);
      chk("R7 vld drops", 64'(ack_vld), 64'h0);
      // R1 level bit clears after request goes away
      req = '0;
      @(negedge clk);
      chk("R1 irq clears", 64'(irq), 64'h0);

      // R4 reprogramming moves source 9 to level 2, priority 6, above fixed source 2
      bus_wr(7'd9, {26'd0, 3'd2, 3'd6});
      do_ack(64'h204, 3'd2);
      chk("R4 moved irq", 64'(irq), 64'h2);
      chk("R4 moved vec", 64'(ack_vec), 64'd73);
      do_ack(64'h204, 3'd3);
      chk("R4 old level empty", 64'(ack_vec), 64'd24);

      // R4 upper bits dropped
      bus_wr(7'd50, 32'hFFFF_FFFF);
      bus_rd_chk("R4 upper bits zero", 7'd50, 32'h3F);
      // R3 hardwired register ignores writes
      bus_wr(7'd5, 32'h3F);
      bus_rd_chk("R3 fixed reads zero", 7'd5, 32'h0);
      do_ack(64'h20, 3'd5);
      chk("R3 fixed still level 5", 64'(irq), 64'h10);
      chk("R3 fixed vec", 64'(ack_vec), 64'd69);
      // R9 unmapped address
      bus_rd_chk("R9 unmapped", 7'd66, 32'h0);
      bus_wr(7'd65, 32'h1234_5678);
      bus_rd_chk("R9 mask hi word", 7'd65, 32'h1234_5678);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule